// File: doc/BRIEF.md
# Two-Wire Serial DAC Load Sequencer

This block lets a controller drive a 12-bit serial-input DAC over only two lines, a serial clock and a data line, with no separate load wire. It brings both lines into the system clock domain. It then produces the three signals the DAC expects: a shift clock, a data line and an active-low load strobe. The shift clock is the inverted serial clock, so the DAC shifts a bit when the serial clock falls. A bit counter in the block counts those shift edges.

A word is thirteen serial clock pulses. The twelve data bits go MSB first, with each bit held on the data line across its whole pulse. Once the twelfth bit has shifted, the counter decodes the load state and drives the strobe low. While the strobe is low the shift clock is held high. The thirteenth pulse is spent in the load state: it neither shifts nor counts. Its falling edge returns the counter to zero, which releases the strobe. After the last word the serial clock simply stops, and everything rests idle.

A power-on clear input returns the counter to its idle state and is passed on to the DAC as its clear line. A one-cycle pulse marks each load.

Top module: `twowire_dac_loader`

## Requirements
- R1: While `rst_n` is low (synchronous), `dac_clk` is 1, `dac_ld_n` is 1, `word_done` is 0, `dac_clr_n` is 0 and the bit count is zero.
- R2: `sclk_in` and `sdi_in` each pass through SYNC_STAGES (default 2) flip-flops. Outside the load state, `dac_clk` equals the inverted synchronised serial clock and `dac_sdi` equals the synchronised data, one register later. Both have the same latency, so a rising edge on `dac_clk` presents the `sdi_in` value that was present when `sclk_in` fell.
- R3: Outside the load state, each falling edge of the synchronised serial clock adds one to the bit count. When the count reaches WORD_BITS (12), the load state is entered. `dac_ld_n` goes low one system clock after the `dac_clk` rising edge that carried the twelfth bit.
- R4: Throughout the load state, and in every cycle in which `dac_ld_n` is low, `dac_clk` stays at 1.
- R5: The next serial clock falling edge after the load state is entered sets the count to zero. `dac_ld_n` returns to 1 one system clock later.
- R6: The thirteenth pulse of a word produces no `dac_clk` rising edge, so each thirteen-pulse word gives exactly 12 `dac_clk` rising edges.
- R7: `word_done` is 1 for exactly one system clock per load: the first cycle in which `dac_ld_n` is low.
- R8: When `por_clr_n` is sampled low, the next clock gives `dac_clr_n` = 0, count zero, `dac_ld_n` = 1, `dac_clk` = 1 and `word_done` = 0, so a partly shifted word is discarded. When `por_clr_n` is high, `dac_clr_n` follows it one clock later.
- R9: Once the serial clock stops low after the thirteenth pulse, `dac_clk` and `dac_ld_n` both stay at 1.
- R10: A DAC that shifts `dac_sdi` in on `dac_clk` rising edges and copies its shift register while `dac_ld_n` is low ends each word holding the 12-bit value sent, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_clr_n | input | 1 | Power-on clear, active low, synchronous to clk |
| sclk_in | input | 1 | Serial clock from the controller, asynchronous |
| sdi_in | input | 1 | Serial data from the controller, asynchronous |
| dac_clk | output | 1 | Shift clock to the DAC, gated inverted serial clock |
| dac_sdi | output | 1 | Serial data to the DAC |
| dac_ld_n | output | 1 | Load strobe to the DAC, active low |
| dac_clr_n | output | 1 | Clear line to the DAC, active low |
| word_done | output | 1 | One-cycle pulse at the start of each load |

## Verification
A wrong bit count shows at the ports within one serial clock pulse. Either `dac_ld_n` falls a pulse early or late, or `dac_clk` shows a thirteenth rising edge, or one is missing. The DAC model in the bench then also latches a shifted or corrupt word. Faults in the gating or in the strobe timing change `dac_clk`, `dac_ld_n` or `word_done` in the very system clock in which they occur. A behavioural model is compared against every output on every clock, so such a fault is reported at its first cycle and not only at the end of the word.

// File: rtl/twl_pkg.sv
// Package for the two-wire DAC load sequencer: default sizes and width helpers.
package twl_pkg;

    localparam int DEF_WORD_BITS   = 12;
    localparam int DEF_SYNC_STAGES = 2;

    // Width of a counter that must hold every value from 0 up to n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/twl_sync.sv
// Multi-bit flop-chain synchroniser.
// Assumes: each bit is an independent slow level (a serial clock or data
// held across a whole serial pulse), so per-bit skew of one cycle is harmless.
module twl_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    // Purpose: shift the inputs through STAGES registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/twl_fall_detect.sv
// Falling-edge detector on a synchronised level.
// Assumes: lvl is already in the clk domain.
module twl_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);

    logic lvl_d;

    // Purpose: remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign fall = lvl_d & ~lvl;

endmodule

// File: rtl/twl_bit_counter.sv
// Shift-edge counter with a decoded load state and a synchronous reload.
// The count rises once per step until it reaches WORD_BITS. That value is the
// load state. The next step reloads zero instead of counting.
// Assumes: step is a single-cycle pulse; clr_n is synchronous to clk.
module twl_bit_counter #(
    parameter int WORD_BITS = 12,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          full
);

    localparam logic [CW-1:0] LOAD_VAL = CW'(WORD_BITS);

    assign full = (count == LOAD_VAL);

    // Purpose: count shift edges and reload to zero on the step after full.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            count <= '0;
        end else if (step) begin
            if (full) count <= '0;
            else      count <= count + CW'(1);
        end
    end

endmodule

// File: rtl/twl_strobe_gen.sv
// Output stage: registers the gated shift clock, data, load strobe,
// completion pulse and DAC clear.
// Assumes: full comes from the bit counter in the same clock domain.
// The shift clock is forced high for the whole load state.
module twl_strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic sclk_s,
    input  logic sdi_s,
    input  logic full,
    output logic dac_clk,
    output logic dac_sdi,
    output logic ld_n,
    output logic word_done,
    output logic clr_out_n
);

    // Purpose: gated, inverted shift clock and load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            dac_clk   <= 1'b1;
            ld_n      <= 1'b1;
            word_done <= 1'b0;
        end else begin
            dac_clk   <= ~sclk_s | full;
            ld_n      <= ~full;
            word_done <= full & ld_n;
        end
    end

    // Purpose: data path to the DAC, aligned with dac_clk.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_sdi <= 1'b0;
        else        dac_sdi <= sdi_s;
    end

    // Purpose: forward the power-on clear; the DAC is held cleared during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_out_n <= 1'b0;
        else        clr_out_n <= clr_n;
    end

endmodule

// File: rtl/twowire_dac_loader.sv
// Two-wire to three-wire DAC load sequencer (top).
// Turns a serial clock and a data line into shift clock, data and load
// strobe for a serial-input DAC. Each word is WORD_BITS data pulses plus one
// extra pulse that is spent in the load state.
// Assumes: sclk_in/sdi_in are asynchronous and slow against clk (each level
// lasts at least two clk cycles); por_clr_n is synchronous to clk.
module twowire_dac_loader #(
    parameter int WORD_BITS   = twl_pkg::DEF_WORD_BITS,
    parameter int SYNC_STAGES = twl_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_clr_n,
    input  logic sclk_in,
    input  logic sdi_in,
    output logic dac_clk,
    output logic dac_sdi,
    output logic dac_ld_n,
    output logic dac_clr_n,
    output logic word_done
);

    localparam int CW = twl_pkg::cnt_width(WORD_BITS);

    logic [1:0]    sync_out;
    logic          sclk_s;
    logic          sdi_s;
    logic          sclk_fall;
    logic [CW-1:0] bit_count;
    logic          load_full;

    twl_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk_in, sdi_in}),
        .dout (sync_out)
    );

    assign sclk_s = sync_out[1];
    assign sdi_s  = sync_out[0];

    twl_fall_detect u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sclk_s),
        .fall (sclk_fall)
    );

    twl_bit_counter #(.WORD_BITS(WORD_BITS), .CW(CW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_n(por_clr_n),
        .step (sclk_fall),
        .count(bit_count),
        .full (load_full)
    );

    twl_strobe_gen u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (por_clr_n),
        .sclk_s   (sclk_s),
        .sdi_s    (sdi_s),
        .full     (load_full),
        .dac_clk  (dac_clk),
        .dac_sdi  (dac_sdi),
        .ld_n     (dac_ld_n),
        .word_done(word_done),
        .clr_out_n(dac_clr_n)
    );

endmodule

// File: rtl/twowire_dac_loader_sva.sv
// Assertion checker for twowire_dac_loader, bound to the top module.
// Assumes: bit_count is the top's internal shift-edge count.
module twowire_dac_loader_sva #(
    parameter int WORD_BITS = 12,
    parameter int CW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          por_clr_n,
    input logic          dac_clk,
    input logic          dac_ld_n,
    input logic          dac_clr_n,
    input logic          word_done,
    input logic [CW-1:0] bit_count
);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count <= CW'(WORD_BITS));

    p_ld_after_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ld_n) |-> dac_clk && $stable(dac_clk));

    p_clk_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> dac_clk);

    p_release_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_ld_n) |-> bit_count == '0);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ld_n) |-> word_done);

    p_done_in_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> !dac_ld_n);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !por_clr_n |=> !dac_clr_n && dac_ld_n && dac_clk && !word_done && bit_count == '0);

endmodule

bind twowire_dac_loader twowire_dac_loader_sva #(.WORD_BITS(WORD_BITS), .CW(CW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_clr_n(por_clr_n),
    .dac_clk  (dac_clk),
    .dac_ld_n (dac_ld_n),
    .dac_clr_n(dac_clr_n),
    .word_done(word_done),
    .bit_count(bit_count)
);

// File: tb/twowire_dac_loader_tb.sv
`timescale 1ns/1ps
module twowire_dac_loader_tb;

    localparam int NSYNC = 2;
    localparam int NBITS = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_clr_n = 1'b1;
    logic sclk_in = 1'b0;
    logic sdi_in = 1'b0;
    logic dac_clk, dac_sdi, dac_ld_n, dac_clr_n, word_done;

    always #2 clk = ~clk;

    twowire_dac_loader #(.WORD_BITS(NBITS), .SYNC_STAGES(NSYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_clr_n(por_clr_n),
        .sclk_in(sclk_in), .sdi_in(sdi_in),
        .dac_clk(dac_clk), .dac_sdi(dac_sdi), .dac_ld_n(dac_ld_n),
        .dac_clr_n(dac_clr_n), .word_done(word_done)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Behavioural reference model, advanced on every rising clock edge.
    bit q_sc[$];
    bit q_sd[$];
    bit m_prev = 0;
    int m_bits = 0;
    bit e_clk = 1, e_sdi = 0, e_ld_n = 1, e_done = 0, e_clr_n = 0;

    function automatic bit delayed(ref bit q[$]);
        int idx = q.size() - 1 - NSYNC;
        return (idx >= 0) ? q[idx] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_sc.delete(); q_sd.delete();
            m_prev = 0; m_bits = 0;
            e_clk = 1; e_sdi = 0; e_ld_n = 1; e_done = 0; e_clr_n = 0;
        end else begin
            bit s, d, in_load;
            q_sc.push_back(sclk_in);
            q_sd.push_back(sdi_in);
            if (q_sc.size() > NSYNC + 1) begin
                void'(q_sc.pop_front());
                void'(q_sd.pop_front());
            end
            s = delayed(q_sc);
            d = delayed(q_sd);
            in_load = (m_bits == NBITS);
            if (!por_clr_n) begin
                m_bits = 0; e_clk = 1; e_ld_n = 1; e_done = 0; e_clr_n = 0;
            end else begin
                e_clk   = !s || in_load;
                e_done  = in_load && e_ld_n;
                e_ld_n  = !in_load;
                e_clr_n = 1;
                if (m_prev && !s) m_bits = in_load ? 0 : m_bits + 1;
            end
            m_prev = s;
            e_sdi  = d;
        end
        started = 1;
    end

    // Per-cycle comparison of every output, away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(dac_clk === e_clk,     "R2 R4 dac_clk",  dac_clk,   e_clk);
            chk(dac_sdi === e_sdi,     "R2 dac_sdi",     dac_sdi,   e_sdi);
            chk(dac_ld_n === e_ld_n,   "R3 R5 dac_ld_n", dac_ld_n,  e_ld_n);
            chk(word_done === e_done,  "R7 word_done",   word_done, e_done);
            chk(dac_clr_n === e_clr_n, "R8 dac_clr_n",   dac_clr_n, e_clr_n);
        end
    end

    // Simple DAC model fed by the outputs.
    logic [NBITS-1:0] dac_sh = '0;
    logic [NBITS-1:0] dac_reg = '0;
    bit dclk_prev = 1;
    int dac_rises = 0;

    always @(negedge clk) begin
        if (started) begin
            if (dac_clk === 1'b1 && !dclk_prev) begin
                dac_sh = {dac_sh[NBITS-2:0], dac_sdi};
                dac_rises++;
            end
            dclk_prev = (dac_clk === 1'b1);
            if (dac_clr_n === 1'b0)      dac_reg = '0;
            else if (dac_ld_n === 1'b0)  dac_reg = dac_sh;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic pulses(input logic [NBITS-1:0] data, input int n, input int h);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sdi_in  = (k < NBITS) ? data[NBITS-1-k] : 1'b0;
            sclk_in = 1'b1;
            repeat (h) @(negedge clk);
            sclk_in = 1'b0;
            repeat (h - 1) @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [NBITS-1:0] data, input int h);
        dac_rises = 0;
        pulses(data, NBITS + 1, h);
        repeat (NSYNC + 6) @(negedge clk);
        chk(dac_reg === data, "R10 latched word", dac_reg, data);
        chk(dac_rises == NBITS, "R6 shift edges per word", dac_rises, NBITS);
        chk(dac_ld_n === 1'b1, "R5 strobe released", dac_ld_n, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(dac_clk === 1'b1 && dac_ld_n === 1'b1, "R1 reset clk/ld", {dac_clk, dac_ld_n}, 3);
        chk(word_done === 1'b0 && dac_clr_n === 1'b0, "R1 reset done/clr", {word_done, dac_clr_n}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        send_word(12'hA5C, 4);
        send_word(12'h000, 4);
        send_word(12'hFFF, 3);
        send_word(12'h801, 2);
        send_word(12'h3C7, 7);

        // Partial word then power-on clear, then a full word.
        pulses(12'h555, 5, 3);
        repeat (NSYNC + 3) @(negedge clk);
        por_clr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(dac_clr_n === 1'b0, "R8 clear forwarded", dac_clr_n, 0);
        chk(dac_reg === '0, "R8 DAC cleared", dac_reg, 0);
        por_clr_n = 1'b1;
        repeat (2) @(negedge clk);
        send_word(12'h6B2, 4);

        // Clear asserted inside the load state.
        pulses(12'hF0F, NBITS, 4);
        repeat (NSYNC + 4) @(negedge clk);
        chk(dac_ld_n === 1'b0, "R3 load state entered", dac_ld_n, 0);
        por_clr_n = 1'b0;
        @(negedge clk);
        por_clr_n = 1'b1;
        @(negedge clk);
        chk(dac_ld_n === 1'b1, "R8 clear exits load", dac_ld_n, 1);
        send_word(12'h1E4, 4);

        // Idle after the last word.
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(dac_clk === 1'b1 && dac_ld_n === 1'b1, "R9 idle rest", {dac_clk, dac_ld_n}, 3);
        end
        finish_run();
    end

endmodule